// File: doc/BRIEF.md
# Receive Address Filter and DMA

This block is the receive half of a packet network interface. Host software loads a start address for the input buffer and a two's-complement maximum word count, then arms the block by setting the enable bit of its control word. The line arrives as half-bit samples with a strobe and a carrier flag. The block decodes the phase-encoded bits and compares the first byte of each packet, the destination, with an 8-bit station address. It accepts the packet on a match, or whatever the destination when the promiscuous bit is set.

Accepted data is assembled into 16-bit words and passed through a small FIFO. It is then written to memory through a request/acknowledge DMA port. The last word of every packet is the check word, and it is never stored. At the end of the packet the block checks the CRC and the alignment, lets the FIFO empty, and then sets done together with the error status. It drops enable, and raises an interrupt if interrupts are enabled.

Top module: `rxdma_filter`

## Requirements
- R1: After reset the control readback, count readback, address readback, `irq` and `dma_req` are all zero.
- R2: The count register is 10 bits wide. A write with `cfg_sel`=0 keeps `cfg_wdata[9:0]` and ignores bits 15..10, and `count_rd` always shows zeros in bits 15..10 above the residual count.
- R3: Each packet starts with one sync bit, which is discarded. Bits follow most significant first, and the first byte is the destination, carried in the high half of the first word. The accepted words are written in order to consecutive addresses, starting at the address loaded with `cfg_sel`=1. `addr_rd` advances by one per write, and `dma_addr`/`dma_data` stay steady while `dma_req` waits for `dma_ack`.
- R4: A packet whose destination differs from `station_addr` while the promiscuous bit is clear is ignored. Count, address and status are left unchanged, nothing is written, and the block stays armed so that the next matching packet is accepted.
- R5: With control bit 1 (promiscuous) set, a packet with any destination is accepted.
- R6: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, without a final inversion, computed over all bits after the sync bit. The packet ends with the check word sent most significant bit first. A wrong check word sets error (control bit 15) along with done.
- R7: Every received word adds one to the count, the check word included, but the check word is never written to memory. A word that arrives when the count is already zero sets error and stops storage. Every word counted before it is still written, so a count equal to the payload size overflows.
- R8: At the end of an accepted packet, done (bit 7) is set and enable (bit 0) cleared only after every stored word has been acknowledged. `irq` is high while done and interrupt enable (bit 6) are both set.
- R9: A word that finds the FIFO full is dropped and sets error.
- R10: A bit cell is two half-cell samples, high then low for 1 and low then high for 0. A cell with equal halves is a code violation and sets error.
- R11: A packet whose bit count after the sync bit is not a multiple of 16 sets error.
- R12: A write with `cfg_sel`=2 loads enable, promiscuous and interrupt enable, and clears done and error. Enable arms the block for the next rising edge of carrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 count, 1 address, 2 control |
| cfg_wdata | input | 16 | Register write data |
| station_addr | input | 8 | Station address for the destination compare |
| line_smp | input | 1 | Half-cell line sample |
| line_stb | input | 1 | Sample valid strobe |
| line_carrier | input | 1 | Carrier present |
| dma_req | output | 1 | Memory write request |
| dma_addr | output | ADDR_W (16) | Memory write address |
| dma_data | output | 16 | Memory write data |
| dma_ack | input | 1 | Memory write accepted |
| count_rd | output | 16 | Residual count readback |
| addr_rd | output | ADDR_W (16) | Next buffer address readback |
| csr_rd | output | 16 | Control and status readback |
| irq | output | 1 | Input-complete interrupt request |

## Verification
End of packet and the DMA drain can overlap: carrier may fall while words are still queued, and done must wait until the last of them has been acknowledged. The bench provokes this by holding back acknowledges for the whole of a long packet. That fills the FIFO and also causes an overrun. It then checks that done stays clear while the words wait, and that exactly a FIFO's worth of leading words reach memory before done is set with error. The same overlap of word counting and DMA writing is swept over packet lengths one to five in matched, mismatched and promiscuous modes. Memory contents, count and address are compared with values computed from the packet.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_HUNT, ST_SYNC, ST_ADDR, ST_RECV, ST_SKIP, ST_DRAIN
    } rx_state_e;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? CRC_POLY : 16'h0000);
    endfunction
endpackage

// File: rtl/rxdma_manch.sv
module rxdma_manch (
    input  logic clk,
    input  logic rst_n,
    input  logic line_smp,
    input  logic line_stb,
    input  logic line_carrier,
    output logic pkt_start,
    output logic pkt_end,
    output logic bit_vld,
    output logic bit_val,
    output logic code_viol
);
    typedef struct packed {
        logic car;
        logic phase;
        logic first;
    } dec_t;

    dec_t dec_d, dec_q;
    logic phase_now;

    always_comb begin
        dec_d     = dec_q;
        pkt_start = line_carrier & ~dec_q.car;
        pkt_end   = ~line_carrier & dec_q.car;
        phase_now = pkt_start ? 1'b0 : dec_q.phase;
        bit_vld   = 1'b0;
        bit_val   = dec_q.first;
        code_viol = 1'b0;
        dec_d.car = line_carrier;
        if (pkt_start) dec_d.phase = 1'b0;
        if (line_carrier && line_stb) begin
            if (!phase_now) begin
                dec_d.first = line_smp;
                dec_d.phase = 1'b1;
            end else begin
                dec_d.phase = 1'b0;
                if (line_smp != dec_q.first) bit_vld = 1'b1;
                else code_viol = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end
endmodule

// File: rtl/rxdma_fifo.sv
module rxdma_fifo #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNTW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PW-1:0]    wr_d, wr_q, rd_d, rd_q;
    logic [CNTW-1:0]  cnt_d, cnt_q;
    logic             do_push, do_pop;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNTW'(DEPTH));
    assign head  = mem_q[rd_q];

    always_comb begin
        do_push = push && !full;
        do_pop  = pop && !empty;
        wr_d    = wr_q;
        rd_d    = rd_q;
        cnt_d   = cnt_q;
        if (do_push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
        if (do_pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
        if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
        else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            wr_q  <= wr_d;
            rd_q  <= rd_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= push_data;
    end
endmodule

// File: rtl/rxdma_filter.sv
module rxdma_filter
    import rxdma_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned CNT_W      = 10,
    parameter int unsigned FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [15:0]       cfg_wdata,
    input  logic [7:0]        station_addr,
    input  logic              line_smp,
    input  logic              line_stb,
    input  logic              line_carrier,
    output logic              dma_req,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [15:0]       dma_data,
    input  logic              dma_ack,
    output logic [15:0]       count_rd,
    output logic [ADDR_W-1:0] addr_rd,
    output logic [15:0]       csr_rd,
    output logic              irq
);
    localparam int unsigned PAD_W = 16 - CNT_W;

    typedef struct packed {
        rx_state_e         st;
        logic              en;
        logic              prom;
        logic              ie;
        logic              done;
        logic              err;
        logic              flaw;
        logic              ovf;
        logic              hold_vld;
        logic [CNT_W-1:0]  wc;
        logic [ADDR_W-1:0] addr;
        logic [14:0]       sh;
        logic [3:0]        bitcnt;
        logic [15:0]       crc;
        logic [15:0]       hold;
    } rx_regs_t;

    rx_regs_t state_d, state_q;

    logic pkt_start, pkt_end, bit_vld, bit_val, code_viol;
    logic fifo_empty, fifo_full, push, pop;
    logic [7:0]  byte_now;
    logic [15:0] word_now;

    rxdma_manch u_manch (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_smp     (line_smp),
        .line_stb     (line_stb),
        .line_carrier (line_carrier),
        .pkt_start    (pkt_start),
        .pkt_end      (pkt_end),
        .bit_vld      (bit_vld),
        .bit_val      (bit_val),
        .code_viol    (code_viol)
    );

    rxdma_fifo #(.WIDTH(16), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (state_q.hold),
        .pop       (pop),
        .head      (dma_data),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    assign dma_req  = !fifo_empty;
    assign dma_addr = state_q.addr;
    assign pop      = dma_req && dma_ack;
    assign byte_now = {state_q.sh[6:0], bit_val};
    assign word_now = {state_q.sh, bit_val};

    always_comb begin
        state_d = state_q;
        push    = 1'b0;
        if (pop) state_d.addr = state_q.addr + 1'b1;
        if (bit_vld) begin
            state_d.sh     = word_now[14:0];
            state_d.crc    = crc_step(state_q.crc, bit_val);
            state_d.bitcnt = state_q.bitcnt + 4'd1;
        end
        unique case (state_q.st)
            ST_HUNT: if (pkt_start) state_d.st = ST_SYNC;
            ST_SYNC: begin
                if (bit_vld) begin
                    state_d.st       = ST_ADDR;
                    state_d.bitcnt   = '0;
                    state_d.crc      = CRC_INIT;
                    state_d.flaw     = 1'b0;
                    state_d.ovf      = 1'b0;
                    state_d.hold_vld = 1'b0;
                end else if (pkt_end) begin
                    state_d.st = ST_HUNT;
                end
            end
            ST_ADDR: begin
                if (code_viol) state_d.flaw = 1'b1;
                if (bit_vld) begin
                    if (state_q.bitcnt == 4'd7)
                        state_d.st = (state_q.prom || byte_now == station_addr) ? ST_RECV : ST_SKIP;
                end else if (pkt_end) begin
                    state_d.st = ST_HUNT;
                end
            end
            ST_RECV: begin
                if (code_viol) state_d.flaw = 1'b1;
                if (bit_vld) begin
                    if (state_q.bitcnt == 4'd15 && !state_q.ovf) begin
                        if (state_q.wc == '0) begin
                            state_d.ovf  = 1'b1;
                            state_d.flaw = 1'b1;
                            if (state_q.hold_vld) begin
                                push             = 1'b1;
                                state_d.hold_vld = 1'b0;
                            end
                        end else begin
                            state_d.wc       = state_q.wc + 1'b1;
                            push             = state_q.hold_vld;
                            state_d.hold     = word_now;
                            state_d.hold_vld = 1'b1;
                        end
                    end
                end else if (pkt_end) begin
                    state_d.st = ST_DRAIN;
                    if (state_q.crc != 16'h0000 || state_q.bitcnt != 4'd0) state_d.flaw = 1'b1;
                end
            end
            ST_SKIP: if (pkt_end) state_d.st = ST_HUNT;
            ST_DRAIN: begin
                if (fifo_empty) begin
                    state_d.st   = ST_IDLE;
                    state_d.done = 1'b1;
                    state_d.en   = 1'b0;
                    state_d.err  = state_q.flaw;
                end
            end
            default: ;
        endcase
        if (push && fifo_full) state_d.flaw = 1'b1;
        if (cfg_wr) begin
            unique case (cfg_sel)
                2'd0: state_d.wc   = cfg_wdata[CNT_W-1:0];
                2'd1: state_d.addr = ADDR_W'(cfg_wdata);
                2'd2: begin
                    state_d.en   = cfg_wdata[0];
                    state_d.prom = cfg_wdata[1];
                    state_d.ie   = cfg_wdata[6];
                    state_d.done = 1'b0;
                    state_d.err  = 1'b0;
                    state_d.st   = cfg_wdata[0] ? ST_HUNT : ST_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign count_rd = {{PAD_W{1'b0}}, state_q.wc};
    assign addr_rd  = state_q.addr;
    assign csr_rd   = {state_q.err, 7'b0, state_q.done, state_q.ie, 4'b0, state_q.prom, state_q.en};
    assign irq      = state_q.done && state_q.ie;
endmodule

// File: rtl/rxdma_filter_chk.sv
module rxdma_filter_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic              dma_req,
    input logic              dma_ack,
    input logic [ADDR_W-1:0] dma_addr,
    input logic [15:0]       dma_data,
    input logic [15:0]       count_rd,
    input logic [ADDR_W-1:0] addr_rd,
    input logic [15:0]       csr_rd,
    input logic              irq
);
    AST_REQ_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack && !cfg_wr) |=> (dma_req && $stable(dma_addr) && $stable(dma_data))); // R3

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack && !cfg_wr) |=> (addr_rd == $past(addr_rd) + 1'b1)); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_wr) && (count_rd != $past(count_rd)))
            |-> (count_rd[CNT_W-1:0] == $past(count_rd[CNT_W-1:0]) + 1'b1)); // R7

    AST_COUNT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        count_rd[15:CNT_W] == '0); // R2

    AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csr_rd[7]) |-> (!dma_req && !csr_rd[0])); // R8

    AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (csr_rd[7] && csr_rd[6])); // R8
endmodule

bind rxdma_filter rxdma_filter_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .dma_req  (dma_req),
    .dma_ack  (dma_ack),
    .dma_addr (dma_addr),
    .dma_data (dma_data),
    .count_rd (count_rd),
    .addr_rd  (addr_rd),
    .csr_rd   (csr_rd),
    .irq      (irq)
);

// File: tb/rxdma_filter_test.sv
module rxdma_filter_test;
    localparam logic [7:0] STA   = 8'h5A;
    localparam int         DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'h0;
    logic        line_smp = 1'b0, line_stb = 1'b0, line_carrier = 1'b0;
    logic        dma_req, dma_ack = 1'b0;
    logic [15:0] dma_addr, dma_data, count_rd, addr_rd, csr_rd;
    logic        irq;

    always #4 clk = ~clk;

    rxdma_filter uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .station_addr(STA), .line_smp(line_smp), .line_stb(line_stb), .line_carrier(line_carrier),
        .dma_req(dma_req), .dma_addr(dma_addr), .dma_data(dma_data), .dma_ack(dma_ack),
        .count_rd(count_rd), .addr_rd(addr_rd), .csr_rd(csr_rd), .irq(irq)
    );

    int ncmp = 0, nbad = 0, nwr = 0;
    bit ack_ok = 1'b1;
    logic [15:0] mem [0:255];
    logic [15:0] pw  [0:15];

    always @(negedge clk) begin
        if (dma_ack) dma_ack = 1'b0;
        else if (dma_req && ack_ok) begin
            mem[dma_addr[7:0]] = dma_data;
            nwr++;
            dma_ack = 1'b1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        ncmp++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [15:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic half(input logic v);
        @(negedge clk); line_smp = v; line_stb = 1'b1;
        @(negedge clk); line_stb = 1'b0;
    endtask

    task automatic tx_bit(input logic b, input bit viol);
        half(b);
        half(viol ? b : ~b);
    endtask

    function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
        return (c << 1) ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
    endfunction

    task automatic send(input int n, input logic [7:0] dst, input bit crc_bad, input bit extra, input int viol_word);
        logic [15:0] c;
        logic [7:0]  xb;
        c  = 16'hFFFF;
        xb = 8'hA5;
        for (int i = 0; i < n; i++)
            pw[i] = (i == 0) ? {dst, 8'(n * 17 + 3)} : 16'((i * 16'h03A5) ^ (n * 16'h1111) ^ 16'h8001);
        @(negedge clk); line_carrier = 1'b1;
        tx_bit(1'b1, 1'b0);
        for (int i = 0; i < n; i++)
            for (int b = 15; b >= 0; b--) begin
                tx_bit(pw[i][b], (i == viol_word) && (b == 4));
                c = crc_bit(c, pw[i][b]);
            end
        if (extra)
            for (int b = 7; b >= 0; b--) begin
                tx_bit(xb[b], 1'b0);
                c = crc_bit(c, xb[b]);
            end
        c = c ^ {15'b0, crc_bad};
        for (int b = 15; b >= 0; b--) tx_bit(c[b], 1'b0);
        @(negedge clk); line_carrier = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_done();
        int t;
        t = 0;
        while (!csr_rd[7] && t < 3000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'hDEAD;
    endtask

    task automatic arm(input logic [9:0] cnt, input logic [15:0] base, input logic [15:0] ctl);
        cfg(2'd0, {6'b101101, cnt});
        cfg(2'd1, base);
        cfg(2'd2, ctl);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nbad++;
            $display("FAIL watchdog: actual expired expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
            $finish;
        end
    end

    initial begin
        logic [9:0]  cnt;
        logic [15:0] base;
        int          w0;
        clear_mem();
        repeat (3) @(negedge clk);
        check("R1 csr", csr_rd, 0);
        check("R1 count", count_rd, 0);
        check("R1 addr", addr_rd, 0);
        check("R1 irq/req", {irq, dma_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        cfg(2'd0, 16'hFFF0);
        check("R2 count upper bits", count_rd, 16'h03F0);

        // mode 0 match, 1 mismatch then match, 2 promiscuous
        for (int mode = 0; mode < 3; mode++)
            for (int n = 1; n <= 5; n++) begin
                cnt  = 10'(1024 - (n + 3));
                base = 16'(mode * 80 + n * 12);
                clear_mem();
                arm(cnt, base, (mode == 2) ? 16'h0043 : 16'h0041);
                w0 = nwr;
                send(n, (mode == 0) ? STA : STA ^ 8'(n), 1'b0, 1'b0, -1);
                if (mode == 1) begin
                    repeat (20) @(negedge clk);
                    check("R4 csr after mismatch", csr_rd, 16'h0041);
                    check("R4 count unchanged", count_rd, {6'b0, cnt});
                    check("R4 addr unchanged", addr_rd, base);
                    check("R4 no writes", nwr - w0, 0);
                    send(n, STA, 1'b0, 1'b0, -1);
                end
                wait_done();
                check((mode == 2) ? "R5 promiscuous csr" : "R8 csr done", csr_rd,
                      (mode == 2) ? 16'h00C2 : 16'h00C0);
                check("R8 irq", irq, 1);
                check("R7 count includes check word", count_rd, {6'b0, 10'(cnt + n + 1)});
                check("R3 addr advance", addr_rd, base + 16'(n));
                check("R3 write count", nwr - w0, n);
                for (int i = 0; i < n; i++)
                    check("R3 data", mem[8'(base + i)], pw[i]);
                check("R7 check word not stored", mem[8'(base + n)], 16'hDEAD);
            end

        // R7 overflow: count equals payload size
        clear_mem();
        arm(10'(1024 - 3), 16'd200, 16'h0041);
        w0 = nwr;
        send(3, STA, 1'b0, 1'b0, -1);
        wait_done();
        check("R7 overflow csr", csr_rd, 16'h80C0);
        check("R7 overflow count", count_rd, 0);
        check("R7 overflow writes", nwr - w0, 3);
        check("R7 overflow last data", mem[8'd202], pw[2]);

        // R6 bad CRC
        arm(10'(1024 - 10), 16'd20, 16'h0041);
        send(2, STA, 1'b1, 1'b0, -1);
        wait_done();
        check("R6 bad crc csr", csr_rd, 16'h80C0);

        // R11 misaligned length
        arm(10'(1024 - 10), 16'd20, 16'h0041);
        send(2, STA, 1'b0, 1'b1, -1);
        wait_done();
        check("R11 misaligned csr", csr_rd, 16'h80C0);

        // R10 code violation
        arm(10'(1024 - 10), 16'd20, 16'h0041);
        send(3, STA, 1'b0, 1'b0, 1);
        wait_done();
        check("R10 violation csr", csr_rd, 16'h80C0);

        // R9 overrun with acks withheld; R8 done waits for drain
        clear_mem();
        ack_ok = 1'b0;
        arm(10'(1024 - 20), 16'd100, 16'h0041);
        w0 = nwr;
        send(8, STA, 1'b0, 1'b0, -1);
        repeat (10) @(negedge clk);
        check("R8 no done while queued", csr_rd[7], 0);
        check("R8 request pending", dma_req, 1);
        ack_ok = 1'b1;
        wait_done();
        check("R9 overrun csr", csr_rd, 16'h80C0);
        check("R9 writes kept", nwr - w0, DEPTH);
        for (int i = 0; i < DEPTH; i++)
            check("R9 kept data", mem[8'(100 + i)], pw[i]);

        // R12 control write clears status
        cfg(2'd2, 16'h0040);
        check("R12 cleared csr", csr_rd, 16'h0040);
        check("R12 irq dropped", irq, 0);

        // R8 interrupt disabled
        arm(10'(1024 - 10), 16'd40, 16'h0001);
        send(1, STA, 1'b0, 1'b0, -1);
        wait_done();
        check("R8 csr no ie", csr_rd, 16'h0080);
        check("R8 no irq", irq, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end
endmodule